// File: doc/BRIEF.md
# Scanned-Channel Result Readback Pointer

This block holds the address that selects which converter result byte a host reads next from an eight-channel result bank. The address is a channel number plus a one-bit byte selector (high or low byte of that channel's result). Software places the pointer on a channel with a write to the start/control register. After that the pointer moves by itself. Every result-byte read steps it. Every completed conversion also steps it while the sequencer is in a scanning mode.

Channels that are disabled in an 8-bit enable mask are skipped. The search for the next enabled channel wraps from the highest channel back to channel 0. The stepping pattern depends on the result width, which a separate width write selects. In 8-bit mode only low bytes are visited, one per enabled channel. In 10-bit mode the pointer visits a channel's high byte, then its low byte, and only then moves on to the next enabled channel.

The result storage and the conversion sequencer live outside this block. They connect through the read strobe and the conversion-done input. The current channel and byte address are outputs the host can sample at any time.

Top module: `scan_rdptr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer clears to channel 0 with the high byte selected (`byte_addr` = 0) and the width becomes 8-bit.
- R2: A pulse on `ctl_wr` loads `ctl_chan` into the channel. It selects the low byte if the width in force after that edge is 8-bit, and the high byte if it is 10-bit. A `width_wr` in the same cycle takes effect first.
- R3: A pulse on `width_wr` sets the width from `width_sel` (0 = 8-bit, 1 = 10-bit). It leaves the channel unchanged and selects the low byte for 8-bit or the high byte for 10-bit.
- R4: In 8-bit mode, a pulse on `rd_stb` moves the pointer to the low byte of the next enabled channel.
- R5: In 10-bit mode, a `rd_stb` while the high byte is selected moves the pointer to the low byte of the same channel. The enable mask is not consulted.
- R6: In 10-bit mode, a `rd_stb` while the low byte is selected moves the pointer to the high byte of the next enabled channel.
- R7: A `conv_done` pulse while `scan_en` is high moves the pointer to the first byte of the next enabled channel (low byte in 8-bit mode, high byte in 10-bit mode). With `scan_en` low, `conv_done` has no effect.
- R8: The next enabled channel is the first channel with its `chan_mask` bit set when counting upward from the current channel plus one, wrapping from 7 to 0. If only the current channel is enabled, the pointer returns to that channel.
- R9: When `chan_mask` is all zeros, any step that needs a channel search leaves both the channel and the byte selector unchanged.
- R10: `byte_addr` bit 0 is the byte selector (0 = high, 1 = low), and bits 3:1 equal `cur_chan`. Both are register outputs that change only on a clock edge.
- R11: When several requests arrive in the same cycle, the priority is `ctl_wr`, then `width_wr`, then `rd_stb`, then a scanning `conv_done`. A read and a scanning conversion in the same cycle make a single step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Start/control register write strobe |
| ctl_chan | input | 3 | Channel number carried by the control write |
| width_wr | input | 1 | Width selection write strobe |
| width_sel | input | 1 | Width: 0 = 8-bit, 1 = 10-bit |
| chan_mask | input | 8 | Channel enable mask, bit n enables channel n |
| rd_stb | input | 1 | One result byte has been read |
| conv_done | input | 1 | Sequencer finished a conversion |
| scan_en | input | 1 | Sequencer is in a scanning mode |
| cur_chan | output | 3 | Current channel address |
| byte_addr | output | 4 | Current result byte address {channel, selector} |

## Verification
Every strobe acts at the next rising edge, and both outputs come straight from registers. Each stimulus therefore has its result due exactly one cycle later, and no input causes a combinational change on the outputs. The driver applies one stimulus per cycle at the falling edge and queues the pointer value the requirements predict for the following edge. The monitor samples one nanosecond after each rising edge and compares that sample with the oldest queued entry, so each result is checked in the cycle it is due. Mask changes are applied together with the strobe they belong to, because the search uses the mask present at the stepping edge.

// File: rtl/scan_rdptr_pkg.sv
// Package: shared step encoding for the readback pointer.
// Assumes: one step kind is chosen per cycle by the priority selector.
package scan_rdptr_pkg;

    typedef enum logic [2:0] {
        STEP_HOLD = 3'd0,
        STEP_LOAD = 3'd1,
        STEP_MODE = 3'd2,
        STEP_READ = 3'd3,
        STEP_SCAN = 3'd4
    } step_e;

endpackage

// File: rtl/rdptr_chan_seek.sv
// Module: rdptr_chan_seek
// Finds the first enabled channel above the current one, wrapping around
// the top of the bank; offset N_CH lands on the current channel itself.
// Assumes: purely combinational, mask bit n enables channel n.
module rdptr_chan_seek #(
    parameter int N_CH = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic [CH_W-1:0] cur,
    input  logic [N_CH-1:0] mask,
    output logic [CH_W-1:0] nxt,
    output logic            found
);

    logic [CH_W-1:0] cand [1:N_CH];
    logic [N_CH:1]   hit;

    // Candidate channel and its enable, one per search offset.
    for (genvar k = 1; k <= N_CH; k++) begin : g_cand
        assign cand[k] = CH_W'((int'(cur) + k) % N_CH);
        assign hit[k]  = mask[cand[k]];
    end

    // Lowest offset with an enabled channel wins.
    always_comb begin
        nxt   = cur;
        found = 1'b0;
        for (int k = N_CH; k >= 1; k--) begin
            if (hit[k]) begin
                nxt   = cand[k];
                found = 1'b1;
            end
        end
    end

    // R8
    always_comb begin
        if (found) begin
            seek_enabled_chk: assert (mask[nxt]);
        end
    end

    // R9
    always_comb begin
        seek_empty_chk: assert (found == (|mask));
    end

endmodule

// File: rtl/rdptr_step_sel.sv
// Module: rdptr_step_sel
// Chooses the single action the pointer takes this cycle from the
// competing requests, in fixed priority order.
// Assumes: all strobes are single-cycle pulses synchronous to clk.
module rdptr_step_sel
    import scan_rdptr_pkg::*;
(
    input  logic  ctl_wr,
    input  logic  width_wr,
    input  logic  rd_stb,
    input  logic  conv_done,
    input  logic  scan_en,
    output step_e step
);

    // Priority: control load, width write, read, scanning conversion.
    always_comb begin
        if (ctl_wr)                      step = STEP_LOAD;
        else if (width_wr)               step = STEP_MODE;
        else if (rd_stb)                 step = STEP_READ;
        else if (conv_done && scan_en)   step = STEP_SCAN;
        else                             step = STEP_HOLD;
    end

endmodule

// File: rtl/rdptr_state_reg.sv
// Module: rdptr_state_reg
// Holds channel, byte selector and width, and applies the chosen step.
// Assumes: seek inputs describe the next enabled channel above chan_q.
module rdptr_state_reg
    import scan_rdptr_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  step_e           step,
    input  logic [CH_W-1:0] ld_chan,
    input  logic            width_wr,
    input  logic            width_sel,
    input  logic [CH_W-1:0] seek_chan,
    input  logic            seek_found,
    output logic [CH_W-1:0] chan_q,
    output logic            lo_q,
    output logic            wide_q
);

    logic [CH_W-1:0] chan_d;
    logic            lo_d;
    logic            wide_d;

    // Next-state selection for the pointer and width.
    always_comb begin
        chan_d = chan_q;
        lo_d   = lo_q;
        wide_d = width_wr ? width_sel : wide_q;
        unique case (step)
            STEP_LOAD: begin
                chan_d = ld_chan;
                lo_d   = ~wide_d;
            end
            STEP_MODE: begin
                lo_d = ~width_sel;
            end
            STEP_READ: begin
                if (wide_q && !lo_q) begin
                    lo_d = 1'b1;
                end else if (seek_found) begin
                    chan_d = seek_chan;
                    lo_d   = ~wide_q;
                end
            end
            STEP_SCAN: begin
                if (seek_found) begin
                    chan_d = seek_chan;
                    lo_d   = ~wide_q;
                end
            end
            default: ;
        endcase
    end

    // Pointer and width registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            lo_q   <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            chan_q <= chan_d;
            lo_q   <= lo_d;
            wide_q <= wide_d;
        end
    end

    // R4
    narrow_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_READ && !wide_q && seek_found) |=> (lo_q && !wide_q));

    // R5
    hi_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_READ && wide_q && !lo_q) |=> (lo_q && chan_q == $past(chan_q)));

    // R6
    lo_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_READ && wide_q && lo_q && seek_found)
            |=> (!lo_q && chan_q == $past(seek_chan)));

    // R9
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_SCAN && !seek_found)
            |=> (chan_q == $past(chan_q) && lo_q == $past(lo_q)));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_LOAD) |=> (chan_q == $past(ld_chan) && lo_q == !wide_q));

endmodule

// File: rtl/scan_rdptr.sv
// Module: scan_rdptr (top)
// Readback address pointer for an eight-channel result bank: loads from a
// control write, steps on reads and scanning conversions, skips disabled
// channels, and walks high/low bytes in 10-bit mode.
// Assumes: result storage and sequencer are outside; strobes are pulses.
module scan_rdptr
    import scan_rdptr_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [CH_W-1:0] ctl_chan,
    input  logic            width_wr,
    input  logic            width_sel,
    input  logic [N_CH-1:0] chan_mask,
    input  logic            rd_stb,
    input  logic            conv_done,
    input  logic            scan_en,
    output logic [CH_W-1:0] cur_chan,
    output logic [CH_W:0]   byte_addr
);

    step_e           step;
    logic [CH_W-1:0] chan_q;
    logic [CH_W-1:0] seek_chan;
    logic            seek_found;
    logic            lo_q;
    logic            wide_q;

    rdptr_step_sel u_sel (
        .ctl_wr    (ctl_wr),
        .width_wr  (width_wr),
        .rd_stb    (rd_stb),
        .conv_done (conv_done),
        .scan_en   (scan_en),
        .step      (step)
    );

    rdptr_chan_seek #(.N_CH(N_CH)) u_seek (
        .cur   (chan_q),
        .mask  (chan_mask),
        .nxt   (seek_chan),
        .found (seek_found)
    );

    rdptr_state_reg #(.N_CH(N_CH)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .ld_chan    (ctl_chan),
        .width_wr   (width_wr),
        .width_sel  (width_sel),
        .seek_chan  (seek_chan),
        .seek_found (seek_found),
        .chan_q     (chan_q),
        .lo_q       (lo_q),
        .wide_q     (wide_q)
    );

    // Outputs: channel and {channel, selector} byte address.
    assign cur_chan  = chan_q;
    assign byte_addr = {chan_q, lo_q};

    // R7
    scan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !scan_en && !ctl_wr && !width_wr && !rd_stb)
            |=> $stable(byte_addr));

    // R1
    reset_chk: assert property (@(posedge clk)
        (!rst_n) |=> (byte_addr == '0));

endmodule

// File: tb/scan_rdptr_tb.sv
`timescale 1ns/1ps
module scan_rdptr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_chan = '0;
    logic       width_wr = 1'b0;
    logic       width_sel = 1'b0;
    logic [7:0] chan_mask = 8'hA5;
    logic       rd_stb = 1'b0;
    logic       conv_done = 1'b0;
    logic       scan_en = 1'b0;
    logic [2:0] cur_chan;
    logic [3:0] byte_addr;

    typedef struct {
        logic [3:0] addr;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    logic [2:0] m_chan = '0;
    logic       m_lo   = 1'b0;
    logic       m_wide = 1'b0;

    always #2 clk = ~clk;

    scan_rdptr dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_chan(ctl_chan),
        .width_wr(width_wr), .width_sel(width_sel), .chan_mask(chan_mask),
        .rd_stb(rd_stb), .conv_done(conv_done), .scan_en(scan_en),
        .cur_chan(cur_chan), .byte_addr(byte_addr)
    );

    // Next enabled channel per R8, -1 when the mask is empty (R9).
    function automatic int seek(input logic [2:0] c, input logic [7:0] m);
        for (int k = 1; k <= 8; k++) begin
            if (m[(int'(c) + k) % 8]) return (int'(c) + k) % 8;
        end
        return -1;
    endfunction

    // Driver: apply one stimulus at the falling edge, queue the expected pointer.
    task automatic drive(input bit cw, input logic [2:0] ch, input bit ww,
                         input bit ws, input bit rd, input bit cd, input bit sc,
                         input logic [7:0] mk, input string tag);
        int n;
        exp_t e;
        @(negedge clk);
        ctl_wr = cw; ctl_chan = ch; width_wr = ww; width_sel = ws;
        rd_stb = rd; conv_done = cd; scan_en = sc; chan_mask = mk;
        n = seek(m_chan, mk);
        if (cw) begin
            if (ww) m_wide = ws;
            m_chan = ch; m_lo = ~m_wide;
        end else if (ww) begin
            m_wide = ws; m_lo = ~ws;
        end else if (rd) begin
            if (m_wide && !m_lo) m_lo = 1'b1;
            else if (n >= 0) begin m_chan = 3'(n); m_lo = ~m_wide; end
        end else if (cd && sc) begin
            if (n >= 0) begin m_chan = 3'(n); m_lo = ~m_wide; end
        end
        e.addr = {m_chan, m_lo};
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: one nanosecond after each edge, compare with the oldest entry.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (byte_addr !== e.addr || cur_chan !== e.addr[3:1]) begin
                    n_bad++;
                    $display("FAIL %s: byte_addr=%h cur_chan=%0d expected byte_addr=%h cur_chan=%0d",
                             e.tag, byte_addr, cur_chan, e.addr, e.addr[3:1]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, checked at the first edge after release
        drive(0, 0, 0, 0, 0, 0, 0, 8'hA5, "R1 reset");
        rst_n = 1'b1;
        // R4 8-bit reads over mask {0,2,5,7}
        drive(0, 0, 0, 0, 1, 0, 0, 8'hA5, "R4 read to ch2");
        drive(0, 0, 0, 0, 1, 0, 0, 8'hA5, "R4 read to ch5");
        drive(0, 0, 0, 0, 1, 0, 0, 8'hA5, "R4 read to ch7");
        drive(0, 0, 0, 0, 1, 0, 0, 8'hA5, "R8 wrap to ch0");
        // R7 conversions with and without scanning
        drive(0, 0, 0, 0, 0, 1, 0, 8'hA5, "R7 no scan ignored");
        drive(0, 0, 0, 0, 0, 1, 1, 8'hA5, "R7 scan step");
        // R3 switch to 10-bit
        drive(0, 0, 1, 1, 0, 0, 0, 8'hA5, "R3 to 10-bit");
        drive(0, 0, 0, 0, 1, 0, 0, 8'hA5, "R5 high to low");
        drive(0, 0, 0, 0, 1, 0, 0, 8'hA5, "R6 low to next high");
        drive(0, 0, 0, 0, 0, 1, 1, 8'hA5, "R7 scan 10-bit");
        // R11 load beats read; read plus scan is one step
        drive(1, 7, 0, 0, 1, 0, 0, 8'hA5, "R11 load over read");
        drive(0, 0, 0, 0, 1, 1, 1, 8'hA5, "R11 single step");
        drive(0, 0, 0, 0, 1, 0, 0, 8'hA5, "R8 R6 wrap high");
        // R9 empty mask
        drive(0, 0, 0, 0, 1, 0, 0, 8'h00, "R5 empty mask high read");
        drive(0, 0, 0, 0, 1, 0, 0, 8'h00, "R9 read hold");
        drive(0, 0, 0, 0, 0, 1, 1, 8'h00, "R9 scan hold");
        // R8 single enabled channel
        drive(0, 0, 0, 0, 1, 0, 0, 8'h10, "R8 only ch4");
        drive(0, 0, 0, 0, 1, 0, 0, 8'h10, "R5 ch4 low");
        drive(0, 0, 0, 0, 1, 0, 0, 8'h10, "R8 back to self");
        // R3/R2 back to 8-bit and load
        drive(0, 0, 1, 0, 0, 0, 0, 8'h10, "R3 to 8-bit");
        drive(1, 3, 0, 0, 0, 0, 0, 8'h10, "R2 load ch3 8-bit");
        drive(1, 6, 1, 1, 0, 0, 0, 8'h10, "R2 load with width");
        drive(0, 0, 1, 0, 1, 0, 0, 8'hFF, "R11 width over read");
        drive(0, 0, 0, 0, 1, 0, 0, 8'hFF, "R4 full mask");
        drive(0, 0, 0, 0, 0, 0, 0, 8'hFF, "R10 idle hold");
        @(negedge clk);
        ctl_wr = 0; width_wr = 0; rd_stb = 0; conv_done = 0; scan_en = 0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule